// File: doc/BRIEF.md
# Strobe-Started Serial Converter Read Controller

This block sits on the host side of a 12-bit serial analog-to-digital converter that starts a conversion on a falling edge of its active-low strobe input. A single request on `start_i` makes the controller run one whole cycle. It drives the strobe low for a set number of system clocks, then waits long enough for the converter to finish. Next it clocks the 16-bit output word in through a divided serial clock, and last it holds off for a quiet interval before another cycle may begin. The word arrives most significant bit first. Its first four bits must be zero and the last twelve carry the sample.

At the end of each read the controller presents the 12-bit sample and a flag on the result port, together with a one-cycle valid pulse. The flag is set when any of the four leading bits was one. The strobe low width, the conversion wait, the quiet interval and the serial clock half period are parameters counted in system clocks. The integrator sets them from the system clock rate so that the serial clock stays at or below the converter's 15 MHz limit, and so that strobe width plus wait covers the 3.3 µs worst-case conversion time. At 50 MHz, a half period of 2 gives 12.5 MHz and a wait of 170 gives 3.4 µs. Every parameter must be at least 1.

Top module: `adc_strobe_reader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `convst_n_o` and `sclk_o` are high, and `busy_o` and `valid_o` are low.
- R2: When `start_i` is sampled high while idle, `convst_n_o` goes low in the next cycle and stays low for exactly `CNV_LOW_CYC` cycles.
- R3: After `convst_n_o` returns high, `sclk_o` stays high for exactly `CNV_WAIT_CYC + SCLK_HALF` cycles before its first fall.
- R4: A read is exactly 16 serial clock pulses. Each pulse is `SCLK_HALF` cycles low followed by `SCLK_HALF` cycles high, and `sclk_o` idles high. `sclk_o` is never low while `convst_n_o` is low.
- R5: `sdata_i` is captured at the system clock edge where `sclk_o` rises. The first four captured bits are the leading bits, and `result_o` holds the last twelve with the earliest of them as bit 11.
- R6: `lead_err_o` is the OR of the four leading bits. It is registered with `result_o`, and `valid_o` is high for exactly one cycle: the cycle in which `sclk_o` shows its 16th rise.
- R7: Counting from the `valid_o` cycle, `busy_o` stays high for exactly `QUIET_CYC` cycles. During those cycles `convst_n_o` and `sclk_o` stay high, so a strobe fall can only follow a cycle with `busy_o` low.
- R8: `start_i` is ignored while `busy_o` is high. It causes no strobe fall and does not change the timing of the cycle in progress.
- R9: `busy_o` is high from the first strobe-low cycle through the last quiet cycle. If `start_i` is high in the first idle cycle, `busy_o` is low for exactly one cycle between two conversion cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request one conversion cycle (taken only while idle) |
| sdata_i | input | 1 | Serial data from the converter |
| convst_n_o | output | 1 | Active-low conversion strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idle high |
| busy_o | output | 1 | A conversion cycle is in progress |
| result_o | output | 12 | Last 12-bit sample |
| lead_err_o | output | 1 | A leading bit of the last word was one |
| valid_o | output | 1 | One-cycle pulse when `result_o` and `lead_err_o` update |

## Verification
The bench builds the block with `SCLK_HALF=2`, `CNV_LOW_CYC=3`, `CNV_WAIT_CYC=12` and `QUIET_CYC=6`. These are short enough that dozens of complete cycles fit in a short run, and they are all distinct, so an off-by-one in any phase or an exchange of two phases changes a measured count. A half period of 2 leaves a system cycle between the converter model's data change on the falling edge and the capture on the rising edge, so a capture on the wrong edge corrupts the word. The random words set the leading bits in about a quarter of the cases, and random start pulses land during the wait and the read.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_STROBE = 3'd1,
    ST_CONV   = 3'd2,
    ST_READ   = 3'd3,
    ST_QUIET  = 3'd4
  } rd_state_e;

  // Counter width able to hold values 0..v, never below one bit.
  function automatic int unsigned cnt_width(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  import adc_rd_pkg::*;

  localparam int unsigned DW = cnt_width(HALF_CYC - 1);
  localparam logic [DW-1:0] LAST = DW'(HALF_CYC - 1);

  logic [DW-1:0] div_q, div_d;
  logic          sclk_q, sclk_d;
  logic          term;

  assign term = (div_q == LAST);

  always_comb begin
    div_d  = div_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      div_d  = '0;
      sclk_d = 1'b1;
    end else if (term) begin
      div_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      div_d  = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      div_q  <= div_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = run_i && term && !sclk_q;
  assign fall_o = run_i && term && sclk_q;

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/frame_capture.sv
module frame_capture #(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned LEAD_BITS  = 4,
  localparam int unsigned RES_BITS  = FRAME_BITS - LEAD_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                bit_en_i,
  input  logic                sdata_i,
  output logic                last_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                lead_err_o,
  output logic                valid_o
);
  import adc_rd_pkg::*;

  localparam int unsigned CW = cnt_width(FRAME_BITS - 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);

  logic [FRAME_BITS-2:0] sh_q, sh_d;
  logic [CW-1:0]         idx_q, idx_d;
  logic [RES_BITS-1:0]   res_q, res_d;
  logic                  err_q, err_d;
  logic                  vld_q, vld_d;
  logic                  word_en;

  assign last_o  = bit_en_i && (idx_q == LAST_IDX);
  assign word_en = last_o;

  always_comb begin
    sh_d  = {sh_q[FRAME_BITS-3:0], sdata_i};
    idx_d = clr_i ? '0 : (idx_q + 1'b1);
    res_d = {sh_q[RES_BITS-2:0], sdata_i};
    err_d = |sh_q[FRAME_BITS-2 -: LEAD_BITS];
    vld_d = word_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      if (bit_en_i)          sh_q  <= sh_d;
      if (bit_en_i || clr_i) idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      err_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      if (word_en) begin
        res_q <= res_d;
        err_q <= err_d;
      end
      vld_q <= vld_d;
    end
  end

  assign result_o   = res_q;
  assign lead_err_o = err_q;
  assign valid_o    = vld_q;

endmodule

// File: rtl/adc_strobe_reader.sv
module adc_strobe_reader #(
  parameter int unsigned SCLK_HALF    = 2,
  parameter int unsigned CNV_LOW_CYC  = 2,
  parameter int unsigned CNV_WAIT_CYC = 170,
  parameter int unsigned QUIET_CYC    = 10,
  parameter int unsigned FRAME_BITS   = 16,
  parameter int unsigned LEAD_BITS    = 4,
  localparam int unsigned RES_BITS    = FRAME_BITS - LEAD_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                sdata_i,
  output logic                convst_n_o,
  output logic                sclk_o,
  output logic                busy_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                lead_err_o,
  output logic                valid_o
);
  import adc_rd_pkg::*;

  localparam int unsigned TMAX = max3(CNV_LOW_CYC, CNV_WAIT_CYC, QUIET_CYC);
  localparam int unsigned TW   = cnt_width(TMAX);
  localparam logic [TW-1:0] LOW_LD   = TW'(CNV_LOW_CYC - 1);
  localparam logic [TW-1:0] WAIT_LD  = TW'(CNV_WAIT_CYC - 1);
  localparam logic [TW-1:0] QUIET_LD = TW'(QUIET_CYC - 1);

  rd_state_e     state_q, state_d;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_done;
  logic          sclk_run;
  logic          sclk_rise;
  logic          sclk_fall;
  logic          frame_clr;
  logic          frame_last;

  // Next-state logic: each timed phase loads the shared timer on entry.
  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    frame_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = LOW_LD;
        end
      end
      ST_STROBE: begin
        if (tmr_done) begin
          state_d  = ST_CONV;
          tmr_load = 1'b1;
          tmr_val  = WAIT_LD;
        end
      end
      ST_CONV: begin
        if (tmr_done) begin
          state_d   = ST_READ;
          frame_clr = 1'b1;
        end
      end
      ST_READ: begin
        if (frame_last) begin
          state_d  = ST_QUIET;
          tmr_load = 1'b1;
          tmr_val  = QUIET_LD;
        end
      end
      ST_QUIET: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign sclk_run   = (state_q == ST_READ);
  assign convst_n_o = (state_q != ST_STROBE);
  assign busy_o     = (state_q != ST_IDLE);

  phase_timer #(
    .W(TW)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .done_o    (tmr_done)
  );

  sclk_gen #(
    .HALF_CYC(SCLK_HALF)
  ) u_sclk (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (sclk_run),
    .sclk_o(sclk_o),
    .rise_o(sclk_rise),
    .fall_o(sclk_fall)
  );

  frame_capture #(
    .FRAME_BITS(FRAME_BITS),
    .LEAD_BITS (LEAD_BITS)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (frame_clr),
    .bit_en_i  (sclk_rise),
    .sdata_i   (sdata_i),
    .last_o    (frame_last),
    .result_o  (result_o),
    .lead_err_o(lead_err_o),
    .valid_o   (valid_o)
  );

  // The falling-edge enable is produced by the divider but not needed here.
  logic unused_fall;
  assign unused_fall = sclk_fall;

endmodule

// File: rtl/adc_strobe_reader_chk.sv
module adc_strobe_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic convst_n_o,
  input logic sclk_o,
  input logic busy_o,
  input logic valid_o
);
  logic [7:0] rise_cnt;

  // Rises seen since the last strobe fall (lags the port by one cycle).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rise_cnt <= '0;
    else if ($fell(convst_n_o)) rise_cnt <= '0;
    else if ($rose(sclk_o))     rise_cnt <= rise_cnt + 1'b1;
  end

  // R2 / R8 / R9: a strobe fall only follows an idle cycle
  a_r8_strobe_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n_o) |-> $past(!busy_o));

  // R4: no serial clock activity while the strobe is low
  a_r4_no_clock_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !convst_n_o |-> sclk_o);

  // R6: valid is a single-cycle pulse
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R3 / R4: the 16th rise coincides with valid
  a_r3_sixteen_rises: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($rose(sclk_o) && rise_cnt == 8'd15));

  // R7: serial clock only falls inside an active cycle with strobe high
  a_r7_fall_inside_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (convst_n_o && busy_o));

  // R9: valid only while busy
  a_r9_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> busy_o);

endmodule

bind adc_strobe_reader adc_strobe_reader_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .convst_n_o(convst_n_o),
  .sclk_o    (sclk_o),
  .busy_o    (busy_o),
  .valid_o   (valid_o)
);

// File: tb/adc_strobe_reader_tb_top.sv
`timescale 1ns/1ps
module adc_strobe_reader_tb_top;

  localparam int HALF  = 2;
  localparam int LOW   = 3;
  localparam int WAITC = 12;
  localparam int QUIET = 6;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        sdata_i;
  logic        convst_n_o;
  logic        sclk_o;
  logic        busy_o;
  logic [11:0] result_o;
  logic        lead_err_o;
  logic        valid_o;

  int n_checks;
  int n_fail;
  logic [15:0] dev_word;
  int bit_i;

  adc_strobe_reader #(
    .SCLK_HALF   (HALF),
    .CNV_LOW_CYC (LOW),
    .CNV_WAIT_CYC(WAITC),
    .QUIET_CYC   (QUIET)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .sdata_i   (sdata_i),
    .convst_n_o(convst_n_o),
    .sclk_o    (sclk_o),
    .busy_o    (busy_o),
    .result_o  (result_o),
    .lead_err_o(lead_err_o),
    .valid_o   (valid_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [11:0] exp_result(input logic [15:0] w);
    return w[11:0];
  endfunction

  function automatic logic exp_err(input logic [15:0] w);
    return |w[15:12];
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Converter model: strobe fall restarts the word, each clock fall shifts a bit out.
  initial begin
    bit_i   = 0;
    sdata_i = 1'b0;
    forever begin
      @(negedge convst_n_o or negedge sclk_o);
      if (!convst_n_o) begin
        bit_i = 0;
      end else if (bit_i < 16) begin
        sdata_i = dev_word[15 - bit_i];
        bit_i++;
      end
    end
  end

  // One complete conversion cycle with measurement of every phase.
  task automatic run_cycle(input logic [15:0] w, input int gap, input logic poke);
    int cnt;
    int rises;
    logic prev_sclk;
    dev_word = w;
    while (busy_o) @(negedge clk);
    for (int g = 0; g < gap; g++) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(!convst_n_o && busy_o, "R2 strobe low after start", convst_n_o, 0);
    cnt = 0;
    while (!convst_n_o && cnt < 1000) begin cnt++; @(negedge clk); end
    check(cnt == LOW, "R2 strobe low width", cnt, LOW);
    cnt = 0;
    while (sclk_o && cnt < 1000) begin
      check(busy_o && convst_n_o, "R9 busy during wait", busy_o, 1);
      if (poke && cnt == 2) start_i = 1'b1;
      if (cnt == 3) start_i = 1'b0;
      cnt++;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(cnt == WAITC + HALF, "R3 wait before first clock fall", cnt, WAITC + HALF);
    rises = 0;
    prev_sclk = sclk_o;
    cnt = 0;
    while (!valid_o && cnt < 1000) begin
      if (poke && cnt == 9) start_i = 1'b1;
      if (cnt == 10) start_i = 1'b0;
      cnt++;
      @(negedge clk);
      if (sclk_o && !prev_sclk) rises++;
      if (!convst_n_o) check(1'b0, "R8 strobe fell during read", 0, 1);
      prev_sclk = sclk_o;
    end
    start_i = 1'b0;
    check(rises == 16 && sclk_o, "R4 pulses per read", rises, 16);
    check(result_o == exp_result(w), "R5 result", result_o, exp_result(w));
    check(lead_err_o == exp_err(w), "R6 leading-bit flag", lead_err_o, exp_err(w));
    cnt = 0;
    while (busy_o && cnt < 1000) begin
      if (!convst_n_o || !sclk_o) check(1'b0, "R7 quiet idle lines", {convst_n_o, sclk_o}, 3);
      cnt++;
      @(negedge clk);
      if (cnt == 1) check(!valid_o, "R6 valid one cycle", valid_o, 0);
    end
    check(cnt == QUIET, "R7 quiet length", cnt, QUIET);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [15:0] w;
    n_checks = 0;
    n_fail   = 0;
    dev_word = 16'h0000;
    start_i  = 1'b0;
    rst_n    = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(convst_n_o && sclk_o && !busy_o && !valid_o, "R1 reset state in reset",
          {convst_n_o, sclk_o, busy_o, valid_o}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    check(convst_n_o && sclk_o && !busy_o && !valid_o, "R1 state after reset",
          {convst_n_o, sclk_o, busy_o, valid_o}, 4'b1100);

    // Directed corner words
    run_cycle(16'h0FFF, 2, 1'b0);
    run_cycle(16'h0000, 1, 1'b1);
    run_cycle(16'h8000, 0, 1'b0);
    run_cycle(16'h0A5A, 3, 1'b1);
    run_cycle(16'hF001, 1, 1'b0);

    // R9: start held in the first idle cycle gives exactly one idle cycle
    dev_word = 16'h0123;
    while (busy_o) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (valid_o == 1'b0) @(negedge clk);
    while (busy_o) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(!convst_n_o && busy_o, "R9 back-to-back restart", convst_n_o, 0);
    while (busy_o) @(negedge clk);

    // Constrained random words, gaps and mid-cycle start pulses
    for (int k = 0; k < 40; k++) begin
      w = 16'($urandom);
      if (($urandom % 4) != 0) w[15:12] = 4'h0;
      run_cycle(w, int'($urandom % 4), logic'($urandom % 2));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule